// File: doc/BRIEF.md
# MSI Termination Register Bank

This block receives message-signalled interrupt writes and turns them into level interrupt lines, one per frame. Storage is organised as frames; each frame holds a set of termination registers, and each register holds one pending bit per vector. An inbound write names a frame and a register through its address and a vector through the low bits of its data. The matching pending bit is then set.

A CPU read port serves two kinds of register. Reading a termination register returns its pending bitmap and clears it in the same access. Reading a frame's summary register returns one bit per termination register of that frame, set when that register holds anything. The summary read has no side effects. An interrupt line per frame stays high while any bit in the frame is pending. With the default parameters there are 16 frames, 8 registers per frame and 16 vectors per register.

Both request ports use a valid/ready handshake. Each `*_ready` is tied high, so the bank never applies back-pressure, and a request is taken on every cycle in which its valid is high. The read response has no ready input. It appears exactly one cycle after the request, marked by `rd_resp_valid`, and cannot be stalled.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every pending bit is zero, every `irq_out` bit is low, `rd_resp_valid` is low and `rd_rdata` is zero.
- R2: An accepted inbound write to a termination address sets pending bit `wr_data[3:0]` of the addressed register. A termination address has bit 23 = 0, the frame in bits 22:19, the register index in bits 18:16, and bits 15:0 = 0. Data bits 31:4 have no effect.
- R3: An accepted read of a termination address returns that register's pending bitmap in `rd_rdata[15:0]`, with bits 31:16 zero. The response appears one cycle after the request, together with `rd_resp_valid`, and the read clears all of that register's pending bits.
- R4: A summary address has bits 23:20 = 4'h8, the frame in bits 19:16, and bits 15:0 = 0. Reading it returns in bit i (i = 0..7) whether register i of that frame holds any pending bit, with bits 31:8 zero. Reading it changes no pending state.
- R5: `irq_out[f]` is high exactly while some pending bit in frame f is set.
- R6: When a write sets a bit in a register during the same cycle that a read clears that register, the read returns the value held before that cycle and the newly written bit remains pending.
- R7: Reads of any other address return zero. Writes to summary addresses or to any other address change no pending state.
- R8: `wr_ready` and `rd_ready` are high in every cycle after reset.
- R9: Once every termination register of a frame has been read with no new write to that frame, the frame's summary reads zero and its `irq_out` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Inbound write request valid |
| wr_ready | output | 1 | Inbound write accepted (always high) |
| wr_addr | input | 24 | Inbound write byte address |
| wr_data | input | 32 | Inbound write data; bits 3:0 select the vector |
| rd_valid | input | 1 | CPU read request valid |
| rd_ready | output | 1 | CPU read accepted (always high) |
| rd_addr | input | 24 | CPU read byte address |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_rdata | output | 32 | Read data |
| irq_out | output | 16 | Per-frame interrupt level |

## Verification
The case hardest to reach from the ports is a set and a read-to-clear hitting the same register in the same cycle. The two request ports must be driven together, with identical frame and register fields, while the register already holds an older bit. The bench stages this directly: it first posts one vector, then issues a second write and the clearing read in a single cycle. It then reads again to show the late bit survived. A long phase that draws addresses from a small pool of registers keeps producing such coincidences, alongside summary reads interleaved with clears. A cycle-level reference model tracks the expected state throughout.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_TERM = 2'd1,
    K_SUMM = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_bank_pkg::*;
#(
  parameter int FR_W   = 4,
  parameter int RG_W   = 3,
  parameter int SPAN_W = 16,
  localparam int ADDR_W = SPAN_W + RG_W + FR_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [FR_W-1:0]   frame,
  output logic [RG_W-1:0]   idx
);
  logic low_zero;
  logic summ_gap_zero;

  assign low_zero      = (addr[SPAN_W-1:0] == '0);
  assign summ_gap_zero = (addr[ADDR_W-2:SPAN_W+FR_W] == '0);

  always_comb begin
    kind  = K_NONE;
    frame = addr[ADDR_W-2 -: FR_W];
    idx   = addr[SPAN_W +: RG_W];
    if (low_zero) begin
      if (!addr[ADDR_W-1]) begin
        kind = K_TERM;
      end else if (summ_gap_zero) begin
        kind  = K_SUMM;
        frame = addr[SPAN_W +: FR_W];
      end
    end
  end
endmodule

// File: rtl/msi_term_reg.sv
module msi_term_reg #(
  parameter int VEC   = 16,
  localparam int VEC_W = $clog2(VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr_en,
  output logic [VEC-1:0]   pend
);
  logic [VEC-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (clr_en ? '0 : pend) | set_mask;
  end

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend[$past(set_vec)]);

  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (pend == '0));

  p_collision_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en) |=> ($countones(pend) == 1));
endmodule

// File: rtl/msi_frame_summary.sv
module msi_frame_summary #(
  parameter int REGS = 8,
  parameter int VEC  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGS*VEC-1:0] frame_bits,
  output logic [REGS-1:0]     summ,
  output logic                irq
);
  for (genvar r = 0; r < REGS; r++) begin : g_or
    assign summ[r] = |frame_bits[r*VEC +: VEC];
  end
  assign irq = |summ;

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (frame_bits != '0));
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_bank_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int REGS   = 8,
  parameter int VEC    = 16,
  parameter int SPAN_W = 16,
  parameter int DATA_W = 32,
  localparam int FR_W   = $clog2(FRAMES),
  localparam int RG_W   = $clog2(REGS),
  localparam int VEC_W  = $clog2(VEC),
  localparam int ADDR_W = SPAN_W + RG_W + FR_W + 1,
  localparam int NREG   = FRAMES * REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_rdata,
  output logic [FRAMES-1:0] irq_out
);
  acc_kind_e       wr_kind, rd_kind;
  logic [FR_W-1:0] wr_frame, rd_frame;
  logic [RG_W-1:0] wr_idx, rd_idx;
  logic            wr_fire, rd_fire;
  logic [NREG*VEC-1:0]  pend_flat;
  logic [NREG-1:0]      summ_flat;
  logic [DATA_W-1:0]    rd_next;
  logic [DATA_W-VEC_W-1:0] unused_wr_hi;

  assign wr_ready     = 1'b1;
  assign rd_ready     = 1'b1;
  assign wr_fire      = wr_valid && wr_ready;
  assign rd_fire      = rd_valid && rd_ready;
  assign unused_wr_hi = wr_data[DATA_W-1:VEC_W];

  msi_addr_decode #(.FR_W(FR_W), .RG_W(RG_W), .SPAN_W(SPAN_W)) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .frame(wr_frame), .idx(wr_idx));

  msi_addr_decode #(.FR_W(FR_W), .RG_W(RG_W), .SPAN_W(SPAN_W)) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .frame(rd_frame), .idx(rd_idx));

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    for (genvar i = 0; i < REGS; i++) begin : g_reg
      logic hit_wr, hit_rd;
      assign hit_wr = wr_fire && (wr_kind == K_TERM) &&
                      (wr_frame == FR_W'(f)) && (wr_idx == RG_W'(i));
      assign hit_rd = rd_fire && (rd_kind == K_TERM) &&
                      (rd_frame == FR_W'(f)) && (rd_idx == RG_W'(i));
      msi_term_reg #(.VEC(VEC)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit_wr), .set_vec(wr_data[VEC_W-1:0]),
        .clr_en(hit_rd),
        .pend(pend_flat[(f*REGS+i)*VEC +: VEC]));
    end
    msi_frame_summary #(.REGS(REGS), .VEC(VEC)) u_summ (
      .clk(clk), .rst_n(rst_n),
      .frame_bits(pend_flat[f*REGS*VEC +: REGS*VEC]),
      .summ(summ_flat[f*REGS +: REGS]),
      .irq(irq_out[f]));
  end

  always_comb begin
    rd_next = '0;
    unique case (rd_kind)
      K_TERM:  rd_next[VEC-1:0]  = pend_flat[({rd_frame, rd_idx})*VEC +: VEC];
      K_SUMM:  rd_next[REGS-1:0] = summ_flat[rd_frame*REGS +: REGS];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_rdata      <= '0;
    end else begin
      rd_resp_valid <= rd_fire;
      rd_rdata      <= rd_fire ? rd_next : '0;
    end
  end

  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_kind == K_NONE) |=> (rd_rdata == '0));

  p_ready_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && rd_ready);

  p_summ_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_kind == K_SUMM && !wr_valid) |=> $stable(pend_flat));
endmodule

// File: tb/msi_term_bank_bench.sv
module msi_term_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0;
  logic        wr_ready, rd_ready, rd_resp_valid;
  logic [23:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_rdata;
  logic [15:0] irq_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  msi_term_bank u_msi_term_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_rdata(rd_rdata), .irq_out(irq_out));

  // reference model
  logic [15:0] mp [16][8];
  logic        exp_rv;
  logic [31:0] exp_rd;
  string       exp_tag;

  function automatic logic [23:0] ta(int f, int i);
    return {1'b0, 4'(f), 3'(i), 16'h0};
  endfunction
  function automatic logic [23:0] sa(int f);
    return {4'h8, 4'(f), 16'h0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < 16; f++) for (int i = 0; i < 8; i++) mp[f][i] = '0;
      exp_rv = 1'b0; exp_rd = '0; exp_tag = "R1";
    end else begin
      exp_rv = rd_valid;
      exp_rd = '0;
      exp_tag = "R7";
      if (rd_valid) begin
        if (rd_addr[15:0] == 16'h0 && !rd_addr[23]) begin
          exp_rd[15:0] = mp[rd_addr[22:19]][rd_addr[18:16]];
          mp[rd_addr[22:19]][rd_addr[18:16]] = '0;
          exp_tag = (wr_valid && wr_addr == rd_addr) ? "R6" : "R3";
        end else if (rd_addr[15:0] == 16'h0 && rd_addr[23:20] == 4'h8) begin
          for (int i = 0; i < 8; i++) exp_rd[i] = (mp[rd_addr[19:16]][i] != 0);
          exp_tag = "R4";
        end
      end
      if (wr_valid && wr_addr[15:0] == 16'h0 && !wr_addr[23])
        mp[wr_addr[22:19]][wr_addr[18:16]][wr_data[3:0]] = 1'b1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] ei;
      for (int f = 0; f < 16; f++) begin
        ei[f] = 1'b0;
        for (int i = 0; i < 8; i++) if (mp[f][i] != 0) ei[f] = 1'b1;
      end
      check("R5 irq", {16'h0, irq_out}, {16'h0, ei});
      check("R8 ready", {30'h0, wr_ready, rd_ready}, 32'h3);
      check({exp_tag, " rvalid"}, {31'h0, rd_resp_valid}, {31'h0, exp_rv});
      if (exp_rv) check({exp_tag, " rdata"}, rd_rdata, exp_rd);
    end
  end

  task automatic step(logic wv, logic [23:0] wa, logic [31:0] wd,
                      logic rv, logic [23:0] ra);
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_valid = rv; rd_addr = ra;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic rd(logic [23:0] a, string tag, logic [31:0] expv);
    step(1'b0, '0, '0, 1'b1, a);
    check(tag, rd_rdata, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid", {31'h0, rd_resp_valid}, 32'h0);
    check("R1 rdata", rd_rdata, 32'h0);
    check("R1 irq", {16'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: set with junk upper data bits, R3: read returns and clears
    wr(ta(3, 5), 32'hABCD_0009);
    rd(ta(3, 5), "R2 set bit 9", 32'h0000_0200);
    rd(ta(3, 5), "R3 cleared", 32'h0);

    // several frames, summary without side effect (R4)
    wr(ta(1, 0), 32'h0);
    wr(ta(1, 7), 32'hF);
    wr(ta(1, 7), 32'h3);
    wr(ta(9, 2), 32'h5);
    rd(sa(1), "R4 summary", 32'h0000_0081);
    rd(sa(1), "R4 no side effect", 32'h0000_0081);
    rd(ta(1, 7), "R3 two bits", 32'h0000_8008);
    rd(sa(1), "R4 after clear", 32'h0000_0001);

    // R6 collision
    wr(ta(2, 1), 32'h4);
    step(1'b1, ta(2, 1), 32'h7, 1'b1, ta(2, 1));
    check("R6 old value", rd_rdata, 32'h0000_0010);
    rd(ta(2, 1), "R6 late bit kept", 32'h0000_0080);

    // R7 ignored writes and unmapped reads
    wr(sa(0), 32'h3);
    wr(ta(0, 0) | 24'h4, 32'h2);
    rd(ta(0, 0), "R7 write ignored", 32'h0);
    check("R7 irq0 low", {31'h0, irq_out[0]}, 32'h0);
    rd(24'h90_0000, "R7 unmapped", 32'h0);
    rd(24'h00_0010, "R7 unmapped low", 32'h0);

    // R9 drain frame 6
    for (int i = 0; i < 8; i++) begin
      wr(ta(6, i), 32'(i));
      wr(ta(6, i), 32'(15 - i));
    end
    rd(sa(6), "R9 full summary", 32'h0000_00FF);
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b1, ta(6, i));
    rd(sa(6), "R9 drained", 32'h0);
    check("R9 irq6 low", {31'h0, irq_out[6]}, 32'h0);

    // mixed traffic on a small register pool (model compares every cycle)
    for (int n = 0; n < 2000; n++) begin
      int k;
      logic [23:0] a1, a2;
      k = $urandom % 4;
      a1 = ta($urandom % 2 + 4, $urandom % 2);
      a2 = (k == 3) ? sa($urandom % 2 + 4) : ta($urandom % 2 + 4, $urandom % 2);
      step($urandom % 2 == 0, a1, $urandom, $urandom % 3 == 0, a2);
    end

    rd(ta(9, 2), "R3 final", 32'h0000_0020);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule